// File: doc/BRIEF.md
# Three-Channel Fly-By DMA Engine

This block is a bus-mastering DMA engine with three channels. Each channel watches a single peripheral request line. When an enabled channel with words left to move sees its request, the engine raises a bus request and waits for the arbiter's grant. The system arbiter is expected to rank this master above both processor masters. Once granted, the engine keeps the bus until the whole transaction for that channel is over. Then it lets go, and the next pending channel can be chosen.

Each beat drives a memory-side address and direction. A one-hot peripheral select goes with it, so that a bridge can move the word straight between memory and the peripheral in the same beat (fly-by). No second bus cycle is spent on the peripheral side. Channel 0 moves up to four words per transaction, back to back. Channels 1 and 2 move one word per transaction, and each of their beats is preceded by a cycle with no valid beat, so a single-word transfer spans at least two bus cycles. Each channel keeps its own address, remaining count and direction, and it raises a sticky completion flag when its count runs out.

Top module: `fbdma_engine`

## Requirements
- R1: Out of reset, bus_req, mem_valid, fly_sel and done are all zero, and every channel holds a zero count.
- R2: A channel is eligible only when its dreq is high, its ch_en bit is set and its remaining count is nonzero. bus_req rises only in the cycle after some channel is eligible. A request from a disabled channel or a channel with a zero count leaves bus_req low.
- R3: From the cycle the engine requests the bus until the last beat of the transaction, bus_req stays high. This holds whatever bus_gnt does after the grant. mem_valid is never high before a grant has been seen. A stalled beat (mem_valid high, mem_rdy low) keeps mem_addr and fly_sel stable.
- R4: When several channels are eligible while the engine is idle, channel 0 wins over channel 1, and channel 1 wins over channel 2. A request that arrives during a transaction is served only after that transaction ends.
- R5: A channel 0 transaction moves min(4, remaining) words. With mem_rdy held high these words go in consecutive cycles.
- R6: A channel 1 or channel 2 transaction moves one word. mem_valid is low in the cycle just before each of its beats, so a word takes at least two cycles. bus_req drops between two such transactions.
- R7: A beat is a cycle with mem_valid and mem_rdy both high. The first beat of a channel uses its configured base address. Each later beat adds 4 bytes, and this running address carries over from one transaction to the next.
- R8: During a beat, mem_write equals the channel's direction bit (1 = peripheral to memory, so a memory write), and fly_sel is the one-hot code of the channel being served (bit i for channel i).
- R9: A channel's done bit rises in the cycle after the beat that brings its count to zero. From then on its requests are ignored. A configuration write to that channel clears done.
- R10: Clearing ch_en during a transaction does not cut the transaction short. Later requests from that channel are ignored.
- R11: A configuration write (cfg_we with cfg_ch selecting the channel) loads base, count and direction. The write is ignored if it targets the channel being served or the one being picked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_base | input | 32 | Start byte address |
| cfg_count | input | 16 | Number of words to move |
| cfg_dir | input | 1 | 1 = peripheral to memory, 0 = memory to peripheral |
| ch_en | input | 3 | Per-channel enable |
| dreq | input | 3 | Per-channel peripheral request |
| bus_req | output | 1 | Bus mastership request, held for the whole transaction |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_valid | output | 1 | Beat valid on the memory side |
| mem_rdy | input | 1 | Memory side accepts the beat |
| mem_addr | output | 32 | Beat byte address |
| mem_write | output | 1 | 1 = memory write, 0 = memory read |
| fly_sel | output | 3 | One-hot peripheral select for the bridge |
| done | output | 3 | Sticky per-channel completion flag |

## Verification
A wrong address or count register shows up at the ports on the very beat it affects, as an unexpected mem_addr. It also shows up in the cycle after the expected last beat, as a missing or early done rise or an extra beat. A bad selection or sequencing state shows in fly_sel order, in a missing idle cycle before a single-word beat, or in bus_req dropping while a burst still has words left. Each of these is visible within one cycle of the faulty edge. The directed scenarios log every beat's channel, address, direction and cycle number, and compare them with the sequences worked out from the requirements.

// File: rtl/fbdma_pkg.sv
package fbdma_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_WAIT = 2'd1,
      SEQ_MOVE = 2'd2
   } seq_state_t;

endpackage

// File: rtl/fbdma_chan.sv
module fbdma_chan #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned WORD_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              dir_i,
   input  logic              beat_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [CNT_W-1:0]  count_o,
   output logic              dir_o,
   output logic              done_o
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);
   localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_o  <= '0;
         count_o <= '0;
         dir_o   <= 1'b0;
         done_o  <= 1'b0;
      end else if (load_i) begin
         addr_o  <= base_i;
         count_o <= count_i;
         dir_o   <= dir_i;
         done_o  <= 1'b0;
      end else if (beat_i && (count_o != '0)) begin
         addr_o  <= addr_o + STEP;
         count_o <= count_o - ONE;
         if (count_o == ONE) begin
            done_o <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/fbdma_arb.sv
module fbdma_arb #(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned CH_W   = 2
) (
   input  logic [NUM_CH-1:0] elig_i,
   output logic              any_o,
   output logic [CH_W-1:0]   pick_o
);

   always_comb begin
      any_o  = |elig_i;
      pick_o = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (elig_i[i]) begin
            pick_o = CH_W'(i);
         end
      end
   end

endmodule

// File: rtl/fbdma_seq.sv
module fbdma_seq
   import fbdma_pkg::*;
#(
   parameter int unsigned           NUM_CH    = 3,
   parameter int unsigned           CH_W      = 2,
   parameter int unsigned           CNT_W     = 16,
   parameter int unsigned           BL_W      = 4,
   parameter logic [NUM_CH*BL_W-1:0] BURST_VEC = {4'd1, 4'd1, 4'd4},
   parameter logic [NUM_CH-1:0]     SLOW_MASK = 3'b110
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             any_i,
   input  logic [CH_W-1:0]  pick_i,
   input  logic [CNT_W-1:0] count_sel_i,
   input  logic             bus_gnt_i,
   input  logic             mem_rdy_i,
   output logic [CH_W-1:0]  act_o,
   output logic [CH_W-1:0]  owner_o,
   output logic             engaged_o,
   output logic             bus_req_o,
   output logic             mem_valid_o,
   output logic             beat_o
);

   localparam logic [BL_W-1:0] LEN_ONE = BL_W'(1);

   seq_state_t      state_q;
   logic [CH_W-1:0] act_q;
   logic [BL_W-1:0] left_q;
   logic [BL_W-1:0] burst_cur;
   logic [BL_W-1:0] first_len;
   logic            slow_cur;
   logic            gap_q;
   logic            busy;
   logic            last_beat;

   assign burst_cur = BURST_VEC[int'(act_q)*BL_W +: BL_W];
   assign slow_cur  = SLOW_MASK[act_q];
   assign busy      = (state_q != SEQ_IDLE);

   always_comb begin
      if (count_sel_i < CNT_W'(burst_cur)) begin
         first_len = count_sel_i[BL_W-1:0];
      end else begin
         first_len = burst_cur;
      end
   end

   assign mem_valid_o = (state_q == SEQ_MOVE) && !gap_q;
   assign beat_o      = mem_valid_o && mem_rdy_i;
   assign last_beat   = beat_o && (left_q == LEN_ONE);
   assign bus_req_o   = busy;
   assign act_o       = act_q;
   assign owner_o     = busy ? act_q : pick_i;
   assign engaged_o   = busy || any_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         act_q   <= '0;
         left_q  <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (any_i) begin
                  act_q   <= pick_i;
                  state_q <= SEQ_WAIT;
               end
            end
            SEQ_WAIT: begin
               if (bus_gnt_i) begin
                  left_q  <= first_len;
                  state_q <= SEQ_MOVE;
               end
            end
            SEQ_MOVE: begin
               if (beat_o) begin
                  left_q <= left_q - LEN_ONE;
                  if (last_beat) begin
                     state_q <= SEQ_IDLE;
                  end
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   generate
      if (SLOW_MASK != '0) begin : g_gap
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               gap_q <= 1'b0;
            end else if ((state_q == SEQ_WAIT) && bus_gnt_i) begin
               gap_q <= slow_cur;
            end else if (state_q == SEQ_MOVE) begin
               if (gap_q) begin
                  gap_q <= 1'b0;
               end else if (beat_o && !last_beat) begin
                  gap_q <= slow_cur;
               end
            end
         end
      end else begin : g_nogap
         assign gap_q = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/fbdma_engine.sv
module fbdma_engine #(
   parameter int unsigned            NUM_CH     = 3,
   parameter int unsigned            ADDR_W     = 32,
   parameter int unsigned            CNT_W      = 16,
   parameter int unsigned            WORD_BYTES = 4,
   parameter int unsigned            BL_W       = 4,
   parameter logic [NUM_CH*BL_W-1:0] BURST_VEC  = {4'd1, 4'd1, 4'd4},
   parameter logic [NUM_CH-1:0]      SLOW_MASK  = 3'b110,
   localparam int unsigned           CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CH_W-1:0]   cfg_ch,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [CNT_W-1:0]  cfg_count,
   input  logic              cfg_dir,
   input  logic [NUM_CH-1:0] ch_en,
   input  logic [NUM_CH-1:0] dreq,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              mem_valid,
   input  logic              mem_rdy,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_write,
   output logic [NUM_CH-1:0] fly_sel,
   output logic [NUM_CH-1:0] done
);

   // elaboration-time parameter checks
   generate
      if (NUM_CH < 2) begin : g_bad_nch
         $error("fbdma_engine: NUM_CH must be at least 2");
      end
      if (WORD_BYTES == 0) begin : g_bad_step
         $error("fbdma_engine: WORD_BYTES must be nonzero");
      end
      if (CNT_W < BL_W) begin : g_bad_cnt
         $error("fbdma_engine: CNT_W must be at least BL_W");
      end
      for (genvar c = 0; c < NUM_CH; c++) begin : g_chk_burst
         if (BURST_VEC[c*BL_W +: BL_W] == '0) begin : g_bad_burst
            $error("fbdma_engine: zero burst length");
         end
      end
   endgenerate

   logic [ADDR_W-1:0] addr_a [NUM_CH];
   logic [CNT_W-1:0]  cnt_a  [NUM_CH];
   logic [NUM_CH-1:0] dir_v;
   logic [NUM_CH-1:0] done_v;
   logic [NUM_CH-1:0] elig_v;
   logic              any_elig;
   logic [CH_W-1:0]   pick;
   logic [CH_W-1:0]   act;
   logic [CH_W-1:0]   owner;
   logic              engaged;
   logic              beat;

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
         logic load_g;
         logic beat_g;

         assign load_g     = cfg_we && (cfg_ch == CH_W'(g)) &&
                             !(engaged && (owner == CH_W'(g)));
         assign beat_g     = beat && (act == CH_W'(g));
         assign elig_v[g]  = dreq[g] && ch_en[g] && (cnt_a[g] != '0);
         assign fly_sel[g] = mem_valid && (act == CH_W'(g));

         fbdma_chan #(
            .ADDR_W     (ADDR_W),
            .CNT_W      (CNT_W),
            .WORD_BYTES (WORD_BYTES)
         ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load_g),
            .base_i  (cfg_base),
            .count_i (cfg_count),
            .dir_i   (cfg_dir),
            .beat_i  (beat_g),
            .addr_o  (addr_a[g]),
            .count_o (cnt_a[g]),
            .dir_o   (dir_v[g]),
            .done_o  (done_v[g])
         );
      end
   endgenerate

   fbdma_arb #(
      .NUM_CH (NUM_CH),
      .CH_W   (CH_W)
   ) u_arb (
      .elig_i (elig_v),
      .any_o  (any_elig),
      .pick_o (pick)
   );

   fbdma_seq #(
      .NUM_CH    (NUM_CH),
      .CH_W      (CH_W),
      .CNT_W     (CNT_W),
      .BL_W      (BL_W),
      .BURST_VEC (BURST_VEC),
      .SLOW_MASK (SLOW_MASK)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .any_i       (any_elig),
      .pick_i      (pick),
      .count_sel_i (cnt_a[act]),
      .bus_gnt_i   (bus_gnt),
      .mem_rdy_i   (mem_rdy),
      .act_o       (act),
      .owner_o     (owner),
      .engaged_o   (engaged),
      .bus_req_o   (bus_req),
      .mem_valid_o (mem_valid),
      .beat_o      (beat)
   );

   assign mem_addr  = addr_a[act];
   assign mem_write = dir_v[act];
   assign done      = done_v;

endmodule

// File: rtl/fbdma_chk.sv
module fbdma_chk #(
   parameter int unsigned       NUM_CH    = 3,
   parameter int unsigned       ADDR_W    = 32,
   parameter logic [NUM_CH-1:0] SLOW_MASK = 3'b110
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] ch_en,
   input logic [NUM_CH-1:0] dreq,
   input logic              bus_req,
   input logic              mem_valid,
   input logic              mem_rdy,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [NUM_CH-1:0] fly_sel,
   input logic [NUM_CH-1:0] done
);

   // R2
   req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) |-> $past(|(dreq & ch_en)));

   // R3
   hold_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_req) |-> $past(mem_valid && mem_rdy));

   // R3
   stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_rdy) |=> (mem_valid && $stable(mem_addr) && $stable(fly_sel)));

   // R8
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> ($onehot(fly_sel) && bus_req));

   // R6
   slow_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && |(fly_sel & SLOW_MASK)) |-> !$past(mem_valid && mem_rdy));

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_done
         // R9
         done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(done[i]) |-> $past(mem_valid && mem_rdy && fly_sel[i]));
      end
   endgenerate

endmodule

bind fbdma_engine fbdma_chk #(
   .NUM_CH    (NUM_CH),
   .ADDR_W    (ADDR_W),
   .SLOW_MASK (SLOW_MASK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ch_en     (ch_en),
   .dreq      (dreq),
   .bus_req   (bus_req),
   .mem_valid (mem_valid),
   .mem_rdy   (mem_rdy),
   .mem_addr  (mem_addr),
   .fly_sel   (fly_sel),
   .done      (done)
);

// File: tb/sim_fbdma_engine.sv
module sim_fbdma_engine;

   logic        clk;
   logic        rst_n;
   logic        cfg_we;
   logic [1:0]  cfg_ch;
   logic [31:0] cfg_base;
   logic [15:0] cfg_count;
   logic        cfg_dir;
   logic [2:0]  ch_en;
   logic [2:0]  dreq;
   logic        bus_req;
   logic        bus_gnt;
   logic        mem_valid;
   logic        mem_rdy;
   logic [31:0] mem_addr;
   logic        mem_write;
   logic [2:0]  fly_sel;
   logic [2:0]  done;

   fbdma_engine u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
      .cfg_base(cfg_base), .cfg_count(cfg_count), .cfg_dir(cfg_dir),
      .ch_en(ch_en), .dreq(dreq), .bus_req(bus_req), .bus_gnt(bus_gnt),
      .mem_valid(mem_valid), .mem_rdy(mem_rdy), .mem_addr(mem_addr),
      .mem_write(mem_write), .fly_sel(fly_sel), .done(done)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   int          lg_n = 0;
   int          lg_ch   [64];
   logic [31:0] lg_addr [64];
   bit          lg_wr   [64];
   int          lg_cyc  [64];
   bit          lg_pv   [64];
   int          lg_idle [64];
   bit          pv = 1'b0;
   int          idle_run = 0;

   function automatic int sel_idx(input logic [2:0] s);
      if (s == 3'b001) return 0;
      if (s == 3'b010) return 1;
      if (s == 3'b100) return 2;
      return -1;
   endfunction

   always @(negedge clk) begin
      cyc++;
      if (rst_n && mem_valid && mem_rdy && lg_n < 64) begin
         lg_ch[lg_n]   = sel_idx(fly_sel);
         lg_addr[lg_n] = mem_addr;
         lg_wr[lg_n]   = mem_write;
         lg_cyc[lg_n]  = cyc;
         lg_pv[lg_n]   = pv;
         lg_idle[lg_n] = idle_run;
         lg_n++;
         idle_run = 0;
      end else if (!bus_req) begin
         idle_run++;
      end
      pv = mem_valid;
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic cfg(input int ch, input logic [31:0] base,
                      input int cnt, input bit dir);
      cfg_we    = 1'b1;
      cfg_ch    = 2'(ch);
      cfg_base  = base;
      cfg_count = 16'(cnt);
      cfg_dir   = dir;
      step(1);
      cfg_we = 1'b0;
   endtask

   task automatic wait_log(input int n, input string req);
      int k = 0;
      while (lg_n < n && k < 2000) begin
         @(negedge clk);
         k++;
      end
      chk(req, "beat arrival", lg_n >= n, 1);
      @(posedge clk);
      #1;
   endtask

   task automatic wait_valid(input string req);
      int k = 0;
      @(negedge clk);
      while (!mem_valid && k < 2000) begin
         @(negedge clk);
         k++;
      end
      chk(req, "mem_valid seen", mem_valid, 1);
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset;
      @(negedge clk);
      // R1
      chk("R1", "bus_req", bus_req, 0);
      chk("R1", "mem_valid", mem_valid, 0);
      chk("R1", "fly_sel", fly_sel, 0);
      chk("R1", "done", done, 0);
      step(1);
   endtask

   task automatic t_ignored;
      int hi = 0;
      int b0 = lg_n;
      cfg(1, 32'h100, 2, 1'b0);
      ch_en = 3'b000;
      dreq  = 3'b010;
      repeat (10) begin
         @(negedge clk);
         if (bus_req) hi++;
      end
      @(posedge clk); #1;
      // R2: disabled channel request
      chk("R2", "bus_req cycles while disabled", hi, 0);
      ch_en = 3'b100;
      dreq  = 3'b100;
      hi = 0;
      repeat (10) begin
         @(negedge clk);
         if (bus_req) hi++;
      end
      @(posedge clk); #1;
      // R2: zero-count channel (never loaded since reset)
      chk("R2", "bus_req cycles zero count", hi, 0);
      chk("R2", "beats while ignored", lg_n - b0, 0);
      dreq = 3'b000;
      step(1);
   endtask

   task automatic t_burst;
      int b = lg_n;
      int hi = 0;
      cfg(0, 32'h1000, 6, 1'b1);
      ch_en = 3'b001;
      dreq  = 3'b001;
      wait_log(b + 6, "R5");
      for (int k = 0; k < 6; k++) begin
         // R7 address sequence, R8 direction and select
         chk("R7", "ch0 addr", lg_addr[b+k], 32'h1000 + 4*k);
         chk("R8", "ch0 write", lg_wr[b+k], 1);
         chk("R8", "ch0 select", lg_ch[b+k], 0);
      end
      for (int k = 0; k < 3; k++) begin
         chk("R5", "burst back-to-back", lg_cyc[b+k+1] - lg_cyc[b+k], 1);
      end
      chk("R5", "bus released after 4 words", lg_idle[b+4] >= 1, 1);
      chk("R5", "tail back-to-back", lg_cyc[b+5] - lg_cyc[b+4], 1);
      @(negedge clk);
      chk("R9", "done after last word", done[0], 1);
      repeat (8) begin
         @(negedge clk);
         if (bus_req) hi++;
      end
      @(posedge clk); #1;
      chk("R9", "requests ignored after done", hi, 0);
      chk("R9", "no extra beats", lg_n - b, 6);
      dreq = 3'b000;
      step(1);
   endtask

   task automatic t_slow;
      int b = lg_n;
      cfg(1, 32'h200, 2, 1'b0);
      ch_en = 3'b010;
      dreq  = 3'b010;
      wait_log(b + 2, "R6");
      for (int k = 0; k < 2; k++) begin
         chk("R6", "idle cycle before slow beat", lg_pv[b+k], 0);
         chk("R7", "ch1 addr", lg_addr[b+k], 32'h200 + 4*k);
         chk("R8", "ch1 read", lg_wr[b+k], 0);
         chk("R8", "ch1 select", lg_ch[b+k], 1);
      end
      chk("R6", "one word per transaction", lg_idle[b+1] >= 1, 1);
      @(negedge clk);
      chk("R9", "ch1 done", done[1], 1);
      dreq = 3'b000;
      step(2);
   endtask

   task automatic t_grant;
      int b = lg_n;
      cfg(2, 32'h500, 1, 1'b0);
      bus_gnt = 1'b0;
      mem_rdy = 1'b0;
      ch_en   = 3'b100;
      dreq    = 3'b100;
      step(5);
      @(negedge clk);
      // R3: waits for grant
      chk("R3", "bus_req before grant", bus_req, 1);
      chk("R3", "no valid before grant", mem_valid, 0);
      @(posedge clk); #1;
      bus_gnt = 1'b1;
      step(1);
      bus_gnt = 1'b0;
      step(4);
      @(negedge clk);
      chk("R3", "bus held after grant dropped", bus_req, 1);
      chk("R3", "stalled beat valid", mem_valid, 1);
      chk("R3", "stalled addr", mem_addr, 32'h500);
      @(posedge clk); #1;
      mem_rdy = 1'b1;
      wait_log(b + 1, "R3");
      chk("R3", "beat addr", lg_addr[b], 32'h500);
      chk("R8", "ch2 select", lg_ch[b], 2);
      step(2);
      @(negedge clk);
      chk("R3", "bus released", bus_req, 0);
      chk("R9", "ch2 done", done[2], 1);
      dreq    = 3'b000;
      bus_gnt = 1'b1;
      step(1);
   endtask

   task automatic t_priority;
      int b = lg_n;
      cfg(0, 32'h2000, 4, 1'b1);
      cfg(1, 32'h2100, 1, 1'b1);
      cfg(2, 32'h2200, 1, 1'b1);
      ch_en = 3'b111;
      dreq  = 3'b111;
      wait_log(b + 6, "R4");
      // R4 fixed order 0 then 1 then 2
      for (int k = 0; k < 4; k++) chk("R4", "first served", lg_ch[b+k], 0);
      chk("R4", "second served", lg_ch[b+4], 1);
      chk("R4", "third served", lg_ch[b+5], 2);
      chk("R7", "ch2 addr", lg_addr[b+5], 32'h2200);
      dreq = 3'b000;
      step(2);
      b = lg_n;
      cfg(2, 32'h2300, 1, 1'b0);
      cfg(0, 32'h2400, 1, 1'b0);
      mem_rdy = 1'b0;
      dreq    = 3'b100;
      wait_valid("R4");
      dreq = 3'b101;
      step(3);
      mem_rdy = 1'b1;
      wait_log(b + 2, "R4");
      chk("R4", "no pre-emption: ch2 first", lg_ch[b], 2);
      chk("R4", "ch0 after", lg_ch[b+1], 0);
      chk("R7", "ch0 addr", lg_addr[b+1], 32'h2400);
      dreq = 3'b000;
      step(2);
   endtask

   task automatic t_disable_mid;
      int b = lg_n;
      cfg(0, 32'h3000, 8, 1'b1);
      mem_rdy = 1'b0;
      ch_en   = 3'b001;
      dreq    = 3'b001;
      wait_valid("R10");
      ch_en   = 3'b000;
      mem_rdy = 1'b1;
      step(20);
      // R10
      chk("R10", "transaction finished", lg_n - b, 4);
      chk("R10", "last addr", lg_addr[b+3], 32'h300C);
      @(negedge clk);
      chk("R10", "bus idle afterwards", bus_req, 0);
      chk("R10", "not done", done[0], 0);
      dreq = 3'b000;
      @(posedge clk); #1;
   endtask

   task automatic t_cfg_busy;
      int b = lg_n;
      cfg(1, 32'h300, 3, 1'b1);
      mem_rdy = 1'b0;
      ch_en   = 3'b010;
      dreq    = 3'b010;
      wait_valid("R11");
      cfg(1, 32'h900, 5, 1'b0);
      mem_rdy = 1'b1;
      wait_log(b + 3, "R11");
      step(6);
      // R11: write during own transaction ignored
      chk("R11", "beats from old config", lg_n - b, 3);
      for (int k = 0; k < 3; k++) begin
         chk("R11", "old addr kept", lg_addr[b+k], 32'h300 + 4*k);
         chk("R11", "old dir kept", lg_wr[b+k], 1);
      end
      @(negedge clk);
      chk("R9", "ch1 done", done[1], 1);
      @(posedge clk); #1;
      dreq = 3'b000;
      cfg(1, 32'h400, 1, 1'b0);
      @(negedge clk);
      chk("R9", "done cleared by config", done[1], 0);
      @(posedge clk); #1;
   endtask

   initial begin
      rst_n     = 1'b0;
      cfg_we    = 1'b0;
      cfg_ch    = '0;
      cfg_base  = '0;
      cfg_count = '0;
      cfg_dir   = 1'b0;
      ch_en     = '0;
      dreq      = '0;
      bus_gnt   = 1'b1;
      mem_rdy   = 1'b1;
      step(3);
      rst_n = 1'b1;
      t_reset();
      t_ignored();
      t_burst();
      t_slow();
      t_grant();
      t_priority();
      t_disable_mid();
      t_cfg_busy();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule